// File: doc/BRIEF.md
# Clock-Synchronous Serial Receive Channel

This block receives 8-bit characters over a two-wire synchronous link made of a serial clock and a data line. Each bit is taken on a rising serial clock edge, and the first bit taken becomes bit 0 of the character. The serial clock comes from one of two places. In internal mode the block divides the system clock and drives the divided clock out. In external mode it takes the clock from a pin, passes it through a two-stage synchronizer and finds its rising edge.

Each completed character is copied into a holding data register, and a full flag is raised. If the previous character has not been read when a new one completes, the block latches an overrun flag instead. It then stops receiving, stops its clock and raises a transmit-inhibit output. It stays in that state until software writes 0 to the overrun flag.

A small four-register host port carries the received data, the flags, the control bits and the clock divider. A single interrupt-enable bit gates both interrupt outputs: the data-ready interrupt and the error interrupt. Both are level outputs.

Top module: `sync_rx_chan`

## Requirements
- R1: After reset the data register reads 0x00, both status flags are 0, both interrupt outputs and `tx_inhibit` are low, and `sclk_out` is low.
- R2: Characters are assembled LSB first. The first sampled bit lands in data bit 0 and the eighth sampled bit lands in bit 7. The bit count restarts after every 8 samples and also whenever reception stops.
- R3: In internal mode `sclk_out` has a period of 2×(N+1) system clocks, where N is the divider register (address 3). It stays low whenever reception is off or frozen. Data is sampled on the edge on which `sclk_out` rises.
- R4: In external mode (control bit 2 = 1), `ext_sclk` passes through two synchronizer flops. The status flag for a character reflects its last rising edge on the third system clock edge after that rising edge, and not before. `sclk_out` stays low in this mode.
- R5: A character that completes while the full flag (status bit 0) is 0 is written to the data register (address 0), and the full flag is set.
- R6: A character that completes while the full flag is 1 sets the overrun flag (status bit 1) and leaves the data register unchanged.
- R7: While the overrun flag is 1, no bits are sampled, `sclk_out` stays low and `tx_inhibit` is high.
- R8: Writing the status register (address 1) with bit 1 = 0 clears the overrun flag. Writing bit 1 = 1 leaves the flag unchanged.
- R9: The full flag is cleared by a host read of address 0, or by a status write with bit 0 = 0. If a clear and a set fall in the same cycle, the set wins.
- R10: `irq_rx_full` equals the full flag ANDed with control bit 1 (interrupt enable). `irq_rx_err` equals the overrun flag ANDed with the same bit. Control bit 0 enables reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe (a read of address 0 clears the full flag) |
| addr | input | 2 | Register select: 0 data, 1 status, 2 control, 3 divider |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data for the selected register (combinational) |
| ext_sclk | input | 1 | External serial clock |
| sdata | input | 1 | Serial data in |
| sclk_out | output | 1 | Internally generated serial clock |
| irq_rx_full | output | 1 | Data-ready interrupt, level |
| irq_rx_err | output | 1 | Receive-error interrupt, level |
| tx_inhibit | output | 1 | High while the channel is frozen by an overrun |

## Verification
In internal mode, the flag and data updates land on the same system clock edge on which `sclk_out` rises for the eighth bit. The bench therefore reads them one time unit after that rise. In external mode the update lands three system clock edges after the pin rises. The bench checks that the full flag is still low one cycle after the pin edge and high three cycles after it. Host writes and reads take effect on the single clock edge inside their strobe. Every flag is read back after the strobe has been dropped, and the frozen state is watched cycle by cycle over a 30-cycle window.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_DATA = 2'd0,
        REG_STAT = 2'd1,
        REG_CTRL = 2'd2,
        REG_DIV  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic ext_clk;
        logic irq_en;
        logic rx_on;
    } ctrl_t;

    typedef struct packed {
        logic overrun;
        logic full;
    } stat_t;

    function automatic logic is_write(input logic wr, input logic [ADDR_W-1:0] a,
                                      input reg_addr_e target);
        return wr && (reg_addr_e'(a) == target);
    endfunction

endpackage

// File: rtl/sync_rx_clkgen.sv
module sync_rx_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_int,
    input  logic             run_ext,
    input  logic [DIV_W-1:0] div_n,
    input  logic             ext_sclk,
    output logic             sclk_out,
    output logic             rise
);
    logic [DIV_W-1:0] cnt_q;
    logic             sclk_q;
    logic [2:0]       sync_q;
    logic             int_rise;
    logic             ext_rise;

    always_ff @(posedge clk) begin
        if (rst || !run_int) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (cnt_q == div_n) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[1:0], ext_sclk};
    end

    always_comb begin
        int_rise = run_int && (cnt_q == div_n) && !sclk_q;
        ext_rise = run_ext && sync_q[1] && !sync_q[2];
        rise     = int_rise || ext_rise;
        sclk_out = sclk_q;
    end

endmodule

// File: rtl/sync_rx_shifter.sv
module sync_rx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              rise,
    input  logic              sdata,
    output logic              done,
    output logic [DATA_W-1:0] char_out
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0]  bitcnt_q;
    logic [DATA_W-2:0] shreg_q;
    logic [DATA_W-1:0] nxt;

    assign nxt      = {sdata, shreg_q};
    assign char_out = nxt;
    assign done     = active && rise && (bitcnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            bitcnt_q <= '0;
            shreg_q  <= '0;
        end else if (rise) begin
            shreg_q  <= nxt[DATA_W-1:1];
            bitcnt_q <= (bitcnt_q == LAST) ? '0 : bitcnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sync_rx_regs.sv
module sync_rx_regs
    import sync_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              done,
    input  logic [DATA_W-1:0] char_in,
    output logic [DATA_W-1:0] rdata,
    output ctrl_t             ctrl_q,
    output stat_t             stat_q,
    output logic [DIV_W-1:0]  div_q,
    output logic [DATA_W-1:0] data_q
);
    logic full_set, full_clr, ovr_set, ovr_clr, stat_wr;

    always_comb begin
        stat_wr  = is_write(wr_en, addr, REG_STAT);
        full_set = done && !stat_q.full;
        full_clr = (rd_en && reg_addr_e'(addr) == REG_DATA) || (stat_wr && !wdata[0]);
        ovr_set  = done && stat_q.full;
        ovr_clr  = stat_wr && !wdata[1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            div_q  <= '0;
            stat_q <= '0;
            data_q <= '0;
        end else begin
            if (is_write(wr_en, addr, REG_CTRL)) ctrl_q <= ctrl_t'(wdata[2:0]);
            if (is_write(wr_en, addr, REG_DIV))  div_q  <= wdata[DIV_W-1:0];
            if (full_set) begin
                data_q      <= char_in;
                stat_q.full <= 1'b1;
            end else if (full_clr) begin
                stat_q.full <= 1'b0;
            end
            if (ovr_set)      stat_q.overrun <= 1'b1;
            else if (ovr_clr) stat_q.overrun <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (reg_addr_e'(addr))
            REG_DATA: rdata = data_q;
            REG_STAT: rdata[1:0] = stat_q;
            REG_CTRL: rdata[2:0] = ctrl_q;
            REG_DIV:  rdata[DIV_W-1:0] = div_q;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/sync_rx_chan.sv
module sync_rx_chan
    import sync_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              ext_sclk,
    input  logic              sdata,
    output logic              sclk_out,
    output logic              irq_rx_full,
    output logic              irq_rx_err,
    output logic              tx_inhibit
);
    ctrl_t             ctrl_q;
    stat_t             stat_q;
    logic [DIV_W-1:0]  div_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] char_w;
    logic              char_done;
    logic              bit_rise;
    logic              run;

    assign run = ctrl_q.rx_on && !stat_q.overrun;

    sync_rx_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk      (clk),
        .rst      (rst),
        .run_int  (run && !ctrl_q.ext_clk),
        .run_ext  (run && ctrl_q.ext_clk),
        .div_n    (div_q),
        .ext_sclk (ext_sclk),
        .sclk_out (sclk_out),
        .rise     (bit_rise)
    );

    sync_rx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .active   (run),
        .rise     (bit_rise),
        .sdata    (sdata),
        .done     (char_done),
        .char_out (char_w)
    );

    sync_rx_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .done    (char_done),
        .char_in (char_w),
        .rdata   (rdata),
        .ctrl_q  (ctrl_q),
        .stat_q  (stat_q),
        .div_q   (div_q),
        .data_q  (data_q)
    );

    assign irq_rx_full = ctrl_q.irq_en && stat_q.full;
    assign irq_rx_err  = ctrl_q.irq_en && stat_q.overrun;
    assign tx_inhibit  = stat_q.overrun;

endmodule

// File: rtl/sync_rx_chan_chk.sv
module sync_rx_chan_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              full,
    input logic              ovr,
    input logic              ie,
    input logic              rx_on,
    input logic              done,
    input logic              rise,
    input logic [DATA_W-1:0] data_q,
    input logic              irq_rx_full,
    input logic              irq_rx_err,
    input logic              sclk_out,
    input logic              wr_en,
    input logic [1:0]        addr,
    input logic              wbit1
);
    // R10: neither interrupt without the shared enable
    p_irq_gate_r10: assert property (@(posedge clk) disable iff (rst)
        (irq_rx_full || irq_rx_err) |-> ie);

    // R5: completion with empty register raises full
    p_full_set_r5: assert property (@(posedge clk) disable iff (rst)
        (done && !full) |=> full);

    // R6: completion while full latches overrun, data held
    p_overrun_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (done && full) |=> (ovr && $stable(data_q)));

    // R7: frozen channel samples nothing
    p_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        ovr |-> !rise);

    // R3: serial clock idles low once reception is off
    p_idle_clk_r3: assert property (@(posedge clk) disable iff (rst)
        !rx_on |=> !sclk_out);

    // R8: writing 0 to the overrun bit clears it
    p_ovr_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd1 && !wbit1 && ovr) |=> !ovr);

endmodule

bind sync_rx_chan sync_rx_chan_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .full        (stat_q.full),
    .ovr         (stat_q.overrun),
    .ie          (ctrl_q.irq_en),
    .rx_on       (ctrl_q.rx_on),
    .done        (char_done),
    .rise        (bit_rise),
    .data_q      (data_q),
    .irq_rx_full (irq_rx_full),
    .irq_rx_err  (irq_rx_err),
    .sclk_out    (sclk_out),
    .wr_en       (wr_en),
    .addr        (addr),
    .wbit1       (wdata[1])
);

// File: tb/sync_rx_chan_bench.sv
module sync_rx_chan_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       ext_sclk = 1'b0;
    logic       sdata = 1'b0;
    logic       sclk_out, irq_rx_full, irq_rx_err, tx_inhibit;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    sync_rx_chan u_sync_rx_chan (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ext_sclk(ext_sclk), .sdata(sdata),
        .sclk_out(sclk_out), .irq_rx_full(irq_rx_full), .irq_rx_err(irq_rx_err),
        .tx_inhibit(tx_inhibit)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic host_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic send_int(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            sdata = b[i];
            @(posedge sclk_out);
            #1;
        end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1", "irq_rx_full", irq_rx_full, 0);
        check("R1", "irq_rx_err", irq_rx_err, 0);
        check("R1", "tx_inhibit", tx_inhibit, 0);
        host_rd(2'd1, d); check("R1", "status", d, 0);
        host_rd(2'd0, d); check("R1", "data", d, 0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (sclk_out) begin check("R3", "sclk idle while off", 1, 0); break; end
        end
        check("R1", "sclk_out low", sclk_out, 0);
    endtask

    task automatic t_int_rx();
        logic [7:0] d;
        host_wr(2'd3, 8'd2);
        host_wr(2'd2, 8'b011);
        send_int(8'hB4);
        check("R5", "full after char", u_sync_rx_chan.rdata === rdata ? irq_rx_full : 0, 1);
        host_wr(2'd2, 8'b010);
        host_rd(2'd0, d); check("R2", "LSB-first data", d, 8'hB4);
        host_rd(2'd1, d); check("R9", "full cleared by data read", d, 0);
        check("R10", "irq_rx_full low after read", irq_rx_full, 0);
    endtask

    task automatic t_period();
        realtime t0, t1;
        logic [7:0] d;
        host_wr(2'd3, 8'd4);
        host_wr(2'd2, 8'b001);
        @(posedge sclk_out); t0 = $realtime;
        @(posedge sclk_out); t1 = $realtime;
        host_wr(2'd2, 8'b000);
        check("R3", "sclk period cycles N=4", int'((t1 - t0) / 8.0), 10);
        @(negedge clk);
        check("R3", "sclk low after disable", sclk_out, 0);
        host_rd(2'd1, d); check("R2", "partial char discarded", d, 0);
    endtask

    task automatic t_ext_rx();
        logic [7:0] d;
        logic [7:0] b = 8'h3C;
        host_wr(2'd2, 8'b111);
        for (int i = 0; i < 8; i++) begin
            sdata = b[i];
            repeat (4) @(negedge clk);
            ext_sclk = 1'b1;
            if (i == 7) begin
                @(negedge clk);
                check("R4", "full not yet after 1 cycle", irq_rx_full, 0);
                repeat (2) @(negedge clk);
                check("R4", "full after 3 cycles", irq_rx_full, 1);
                repeat (1) @(negedge clk);
            end else begin
                repeat (4) @(negedge clk);
            end
            ext_sclk = 1'b0;
            check("R4", "sclk_out low in ext mode", sclk_out, 0);
        end
        host_wr(2'd2, 8'b110);
        host_rd(2'd1, d); check("R5", "status full ext", d, 8'h01);
        addr = 2'd0; #1 check("R2", "ext data", rdata, 8'h3C);
        host_wr(2'd1, 8'b10);
        host_rd(2'd1, d); check("R9", "full cleared by status write", d, 0);
    endtask

    task automatic t_overrun();
        logic [7:0] d;
        bit moved;
        host_wr(2'd3, 8'd2);
        host_wr(2'd2, 8'b011);
        send_int(8'h11);
        send_int(8'h22);
        repeat (2) @(negedge clk);
        check("R6", "irq_rx_err", irq_rx_err, 1);
        check("R7", "tx_inhibit", tx_inhibit, 1);
        moved = 1'b0;
        for (int i = 0; i < 30; i++) begin
            sdata = ~sdata;
            @(negedge clk);
            if (sclk_out) moved = 1'b1;
        end
        check("R7", "sclk frozen", moved, 0);
        host_rd(2'd1, d); check("R6", "status both flags", d, 8'h03);
        addr = 2'd0; #1 check("R6", "data kept old char", rdata, 8'h11);
        host_wr(2'd1, 8'b11);
        host_rd(2'd1, d); check("R8", "write 1 keeps overrun", d, 8'h03);
        host_wr(2'd2, 8'b010);
        host_wr(2'd1, 8'b01);
        host_rd(2'd1, d); check("R8", "overrun cleared, full kept", d, 8'h01);
        check("R8", "tx_inhibit released", tx_inhibit, 0);
        host_rd(2'd0, d); check("R6", "data still first", d, 8'h11);
        host_rd(2'd1, d); check("R9", "full cleared", d, 0);
    endtask

    task automatic t_irq_off();
        logic [7:0] d;
        host_wr(2'd3, 8'd2);
        host_wr(2'd2, 8'b001);
        send_int(8'h5A);
        host_wr(2'd2, 8'b000);
        host_rd(2'd1, d); check("R5", "full set", d, 8'h01);
        check("R10", "irq_rx_full gated off", irq_rx_full, 0);
        host_wr(2'd2, 8'b010);
        @(negedge clk);
        check("R10", "irq_rx_full with enable", irq_rx_full, 1);
        host_rd(2'd0, d); check("R2", "data 5A", d, 8'h5A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_int_rx();
        t_period();
        t_ext_rx();
        t_overrun();
        t_irq_off();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule